// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two levels of state. The first level records recent branch outcomes as k-bit history patterns. In per-address mode there is a small table of history registers, one chosen by the branch PC. In global mode a single shift register is shared by every branch. The second level is a table of 2-bit saturating counters with one counter per possible history pattern. The history pattern, and not the PC, selects the counter that makes the prediction.

A fetch stage presents a PC on the predict port and reads back a taken/not-taken decision in the same cycle. When a branch resolves, its PC and actual outcome are presented on the update port. The update port has only a valid strobe: there is no back-pressure, and an update is accepted in every cycle in which `upd_valid` is high.

Top module: `twolvl_pred`

## Requirements
- R1: In per-address mode (`GLOBAL_MODE`=0) the history register is selected by PC bits [2 +: log2(HIST_ENTRIES)]. All other PC bits have no effect on predictions or on updates.
- R2: In global mode (`GLOBAL_MODE`=1) one history register records the outcomes of all updated branches in update order. Every PC reads that same register.
- R3: On an accepted update, the outcome (1 = taken) is shifted into bit 0 of the selected history register. The remaining bits move up one position and the oldest bit is discarded.
- R4: The counter table is indexed by the k-bit history of the predicting branch. `pred_taken` is 1 exactly when that counter holds 2 or 3.
- R5: On an update, the counter indexed by the history as it was before the shift is incremented on taken and decremented on not-taken. It saturates at 3 and at 0.
- R6: `pred_taken` is combinational from `pred_pc` and the current state. In the cycle of an update, predictions still use the old state, and the new state is used from the next cycle. With `upd_valid` low, the state does not change.
- R7: After reset, every history register is 0 and every counter is 1, so every PC predicts not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | PC of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Update strobe; accepted every cycle it is high |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A corrupted history register sends later lookups to the wrong counter. The prediction stays correct until that counter differs from the intended one, which can take several updates. A counter error shows on `pred_taken` only when it crosses the 1/2 boundary. For these reasons the bench compares every PC's prediction against an arithmetic model in every cycle of long training sequences, in both modes. Repeated taken runs push counters into saturation, so that a missing clamp or a wrong shift shows within a few updates.

// File: rtl/twolvl_pkg.sv
package twolvl_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd1;

  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
    else       nxt = (cur == 2'd0) ? cur : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/twolvl_hist.sv
module twolvl_hist #(
  parameter int HIST_LEN = 4,
  parameter int ENTRIES  = 8,
  parameter int IDX_W    = 3,
  parameter bit GLOBAL   = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_a_idx,
  output logic [HIST_LEN-1:0] rd_a_hist,
  input  logic [IDX_W-1:0]    rd_b_idx,
  output logic [HIST_LEN-1:0] rd_b_hist,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_taken
);
  generate
    if (GLOBAL) begin : g_global
      logic [HIST_LEN-1:0] shr_q;
      logic [3*IDX_W-1:0]  unused_idx;
      assign unused_idx = {rd_a_idx, rd_b_idx, wr_idx};
      assign rd_a_hist = shr_q;
      assign rd_b_hist = shr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     shr_q <= '0;
        else if (wr_en) shr_q <= {shr_q[HIST_LEN-2:0], wr_taken};
      end
    end else begin : g_local
      logic [HIST_LEN-1:0] tbl_q [ENTRIES];
      assign rd_a_hist = tbl_q[rd_a_idx];
      assign rd_b_hist = tbl_q[rd_b_idx];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else if (wr_en) begin
          tbl_q[wr_idx] <= {tbl_q[wr_idx][HIST_LEN-2:0], wr_taken};
        end
      end
    end
  endgenerate
endmodule

// File: rtl/twolvl_pattern.sv
module twolvl_pattern
  import twolvl_pkg::*;
#(
  parameter int HIST_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HIST_LEN-1:0] rd_hist,
  output ctr_t                rd_ctr,
  input  logic                up_en,
  input  logic [HIST_LEN-1:0] up_hist,
  input  logic                up_taken,
  output ctr_t                up_ctr
);
  localparam int PATTERNS = 1 << HIST_LEN;

  ctr_t ctr_q [PATTERNS];

  assign rd_ctr = ctr_q[rd_hist];
  assign up_ctr = ctr_q[up_hist];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PATTERNS; i++) ctr_q[i] <= CTR_RESET;
    end else if (up_en) begin
      ctr_q[up_hist] <= ctr_next(ctr_q[up_hist], up_taken);
    end
  end
endmodule

// File: rtl/twolvl_pred.sv
module twolvl_pred
  import twolvl_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int HIST_LEN     = 4,
  parameter int HIST_ENTRIES = 8,
  parameter bit GLOBAL_MODE  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int IDX_W = $clog2(HIST_ENTRIES);
  localparam int IDX_LO = 2;

  logic [IDX_W-1:0]    pred_idx, upd_idx;
  logic [HIST_LEN-1:0] pred_hist, upd_hist;
  ctr_t                pred_ctr, upd_ctr;
  logic [2*(PC_W-IDX_W)-1:0] unused_pc;

  assign pred_idx  = pred_pc[IDX_LO +: IDX_W];
  assign upd_idx   = upd_pc[IDX_LO +: IDX_W];
  assign unused_pc = {pred_pc[PC_W-1:IDX_LO+IDX_W], pred_pc[IDX_LO-1:0],
                      upd_pc[PC_W-1:IDX_LO+IDX_W],  upd_pc[IDX_LO-1:0]};

  twolvl_hist #(
    .HIST_LEN(HIST_LEN), .ENTRIES(HIST_ENTRIES), .IDX_W(IDX_W), .GLOBAL(GLOBAL_MODE)
  ) u_hist (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(pred_idx), .rd_a_hist(pred_hist),
    .rd_b_idx(upd_idx),  .rd_b_hist(upd_hist),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken)
  );

  twolvl_pattern #(.HIST_LEN(HIST_LEN)) u_pat (
    .clk(clk), .rst_n(rst_n),
    .rd_hist(pred_hist), .rd_ctr(pred_ctr),
    .up_en(upd_valid), .up_hist(upd_hist), .up_taken(upd_taken), .up_ctr(upd_ctr)
  );

  assign pred_taken = pred_ctr[1];
endmodule

// File: rtl/twolvl_pred_chk.sv
module twolvl_pred_chk #(
  parameter int HIST_LEN = 4,
  parameter int IDX_W    = 3,
  parameter bit GLOBAL   = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                upd_valid,
  input logic                upd_taken,
  input logic [IDX_W-1:0]    upd_idx,
  input logic [HIST_LEN-1:0] upd_hist,
  input logic [1:0]          upd_ctr,
  input logic [IDX_W-1:0]    pred_idx,
  input logic                pred_taken
);
  // R3 (and R1/R2 selection): back-to-back updates to the same register see the shifted value
  assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $past(upd_valid) && (GLOBAL || upd_idx == $past(upd_idx)))
    |-> upd_hist == {$past(upd_hist[HIST_LEN-2:0]), $past(upd_taken)});

  // R5: a counter touched twice in a row moved by one step, clamped at 0 and 3
  assert_ctr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $past(upd_valid) && upd_hist == $past(upd_hist))
    |-> upd_ctr == ($past(upd_taken)
                    ? (($past(upd_ctr) == 2'd3) ? 2'd3 : $past(upd_ctr) + 2'd1)
                    : (($past(upd_ctr) == 2'd0) ? 2'd0 : $past(upd_ctr) - 2'd1)));

  // R6: without an update the prediction for an unchanged PC holds
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(upd_valid) && $stable(pred_idx)) |-> $stable(pred_taken));

  // R7: leaving reset every PC predicts not-taken
  assert_reset_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pred_taken);

  // R7: counters leave reset at 1, so the first update leaves them at 0 or 2
  assert_first_ctr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && upd_valid) |-> upd_ctr == 2'd1);
endmodule

bind twolvl_pred twolvl_pred_chk #(
  .HIST_LEN(HIST_LEN), .IDX_W(IDX_W), .GLOBAL(GLOBAL_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .upd_idx(upd_idx), .upd_hist(upd_hist), .upd_ctr(upd_ctr),
  .pred_idx(pred_idx), .pred_taken(pred_taken)
);

// File: tb/tb_twolvl_pred.sv
module tb_twolvl_pred;
  localparam int K = 3;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pt_loc, pt_glb;

  int total = 0;
  int bad = 0;

  int mh [N];
  int mg;
  int mc_l [1<<K];
  int mc_g [1<<K];

  always #10 clk = ~clk;

  twolvl_pred #(.PC_W(32), .HIST_LEN(K), .HIST_ENTRIES(N), .GLOBAL_MODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_loc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  twolvl_pred #(.PC_W(32), .HIST_LEN(K), .HIST_ENTRIES(N), .GLOBAL_MODE(1'b1)) dut_glb (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_glb),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  task automatic model_reset();
    for (int i = 0; i < N; i++) mh[i] = 0;
    mg = 0;
    for (int i = 0; i < (1<<K); i++) begin mc_l[i] = 1; mc_g[i] = 1; end
  endtask

  function automatic int sat(input int c, input bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One cycle: drive an (optional) update, check all PCs before the edge, then advance the model.
  task automatic step(input bit v, input int slot, input bit t, input int hi, input string tag);
    @(negedge clk);
    upd_valid = v;
    upd_pc    = {hi[29:0], 2'b00} & 32'hFFFF_FFF0 | (32'(slot) << 2) | 32'(hi & 3);
    upd_taken = t;
    for (int p = 0; p < N; p++) begin
      pred_pc = {hi[27:0] ^ 28'h5A5, p[1:0], 2'(hi + p)};
      #1;
      check(pt_loc, mc_l[mh[p]] >= 2, {tag, " R1 R4 R6 per-address"});
      check(pt_glb, mc_g[mg] >= 2, {tag, " R2 R4 R6 global"});
    end
    @(posedge clk);
    if (v) begin
      mc_l[mh[slot]] = sat(mc_l[mh[slot]], t);
      mh[slot] = ((mh[slot] << 1) | int'(t)) & ((1<<K) - 1);
      mc_g[mg] = sat(mc_g[mg], t);
      mg = ((mg << 1) | int'(t)) & ((1<<K) - 1);
    end
  endtask

  initial begin
    #3_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R7: reset state over many PCs
    for (int i = 0; i < 16; i++) begin
      pred_pc = 32'(i * 32'h0101_0104);
      #1;
      check(pt_loc, 1'b0, "R7 reset per-address");
      check(pt_glb, 1'b0, "R7 reset global");
    end

    // R1 R2 R3 R5: mixed training sequence with idle gaps (R6)
    for (int i = 0; i < 300; i++) begin
      int slot;
      bit t;
      slot = ((i * 7) >> 1) % N;
      t = ((i % 3) != 0) ^ (((i * 5) % 11) < 2) ^ (slot == 3);
      step((i % 9) != 4, slot, t, i * 37 + 11, "R3 R5 train");
    end

    // R5: saturation at 3 then single not-taken, and saturation at 0
    for (int i = 0; i < 12; i++) step(1'b1, 0, 1'b1, i, "R5 sat-high");
    step(1'b1, 0, 1'b0, 99, "R5 one-miss");
    for (int i = 0; i < 12; i++) step(1'b1, 2, 1'b0, i + 7, "R5 sat-low");
    step(1'b0, 0, 1'b0, 5, "R6 idle");

    // R7: reset again mid-run
    @(negedge clk); rst_n = 1'b0; upd_valid = 1'b0;
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 0, 1'b0, 3, "R7 re-reset");

    // R1: alternating pattern per slot, high PC bits varied
    for (int i = 0; i < 120; i++) step(1'b1, i % N, (i / N) % 2 == 0, i * 1013, "R1 R2 alternate");
    step(1'b0, 0, 1'b0, 1, "R6 final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule